// File: doc/BRIEF.md
# Software SMI Request Generator

This block turns a set of system-management interrupt request flags into one SMI request level for the processor side. Each of nine request sources has a status flag and a matching enable bit. A global gate qualifies the whole set. The output is raised while the gate is on and at least one source has both its flag and its enable set.

Software reaches the block through two paths. The first is a 32-bit configuration write port with byte lanes, which reaches a control register and a request-status register. The second is an 8-bit I/O port pair for power-management handshaking: a command port and a data port. A byte written to the command port is kept for readback. When source 7 is enabled, that write also raises request flag 7, so firmware can enter system management mode with a single I/O write. A byte written to the data port is only stored. Other logic raises the remaining flags through a request-input vector, where a rising edge on a line sets its flag.

The output stage is a two-state machine: `SMI_IDLE` and `SMI_ASSERT`. The transition IDLE→ASSERT is taken when a gated enabled request is pending. The transition ASSERT→IDLE is taken when none is pending. Reset returns the machine to `SMI_IDLE`.

Top module: `smi_swreq_gen`

## Requirements
- R1: The control register sits at configuration offset 0xA0. Bit 0 is the global gate and bits 24:16 are the nine enable bits, source i at bit 16+i. All other bits read 0. A write updates only the bits whose byte lane enable is set: lane 0 holds bit 0, lane 2 holds bits 23:16 and lane 3 holds bit 24.
- R2: The request-status register sits at offset 0xA8. Bits 24:16 are the nine request flags, source i at bit 16+i, and all other bits read 0. A write stores the written value into the flags whose byte lane is enabled, which is how software clears flags. Writes to any other offset change nothing, and reads of any other offset return 0.
- R3: `smi_req` is high exactly when, one clock earlier, the gate was 1 and some source had both its flag and its enable set. It therefore follows a register write on the second rising edge after the write is presented.
- R4: An I/O write to port 0xB2 stores the byte. An I/O read of 0xB2 returns it.
- R5: An I/O write to port 0xB2 sets request flag 7 on the same edge if enable bit 7 is 1, and leaves flag 7 unchanged if it is 0.
- R6: An I/O write to port 0xB3 stores the byte, which reads back at 0xB3. It changes neither the request flags nor `smi_req`.
- R7: A 0→1 transition on `req_in[i]` sets flag i. A line that is held high does not set the flag again after software clears it.
- R8: A set event from `req_in` or from the command port wins over a status-register write to the same flag in the same cycle.
- R9: Reset (`rst_n` low, asynchronous) clears the gate, the enables, the flags, both port bytes and `smi_req`.
- R10: `io_rdata` is 0 when `io_rd` is low or when the address is neither port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration offset, used for both writes and reads |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Byte lane enables for configuration writes |
| cfg_rdata | output | 32 | Register at `cfg_addr` (combinational) |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write byte |
| io_rdata | output | 8 | I/O read byte (combinational) |
| req_in | input | 9 | Hardware request lines, rising-edge sensitive |
| smi_req | output | 1 | SMI request level |

## Verification
The checker assumes that every input changes away from the rising edge, and that `req_in` is low while reset is applied. With that assumption, the first edge seen after reset is a real 0→1 transition. The bench drives every input on the falling edge and keeps `req_in` at 0 through each reset. A configuration write and an I/O write may land in the same cycle; the bench does this on purpose for the priority case and nowhere else.

// File: rtl/smi_swreq_pkg.sv
package smi_swreq_pkg;

    // Output stage states
    typedef enum logic [0:0] {
        SMI_IDLE   = 1'b0,
        SMI_ASSERT = 1'b1
    } smi_state_e;

    localparam int CFG_DW   = 32;
    localparam int CFG_BE_W = CFG_DW / 8;

endpackage

// File: rtl/smi_cfg_regs.sv
module smi_cfg_regs
    import smi_swreq_pkg::*;
#(
    parameter int                NUM_SRC   = 9,
    parameter int                FIELD_LSB = 16,
    parameter int                CFG_AW    = 8,
    parameter logic [CFG_AW-1:0] CTRL_OFF  = 'hA0,
    parameter logic [CFG_AW-1:0] STS_OFF   = 'hA8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [CFG_DW-1:0]   cfg_wdata,
    input  logic [CFG_BE_W-1:0] cfg_be,
    input  logic [NUM_SRC-1:0]  set_vec,
    output logic                gate_o,
    output logic [NUM_SRC-1:0]  en_o,
    output logic [NUM_SRC-1:0]  sts_o,
    output logic [CFG_DW-1:0]   cfg_rdata
);

    localparam int FIELD_MSB = FIELD_LSB + NUM_SRC - 1;

    logic               gate_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] sts_q;
    logic [NUM_SRC-1:0] en_wr;
    logic [NUM_SRC-1:0] sts_wr;
    logic               hit_ctrl;
    logic               hit_sts;
    logic               unused_wdata;

    assign unused_wdata = ^cfg_wdata;
    assign hit_ctrl     = cfg_wr && (cfg_addr == CTRL_OFF);
    assign hit_sts      = cfg_wr && (cfg_addr == STS_OFF);

    // Per-bit lane merge of the write data with the held field
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_field
        localparam int BITPOS = FIELD_LSB + i;
        localparam int LANE   = BITPOS / 8;
        assign en_wr[i]  = cfg_be[LANE] ? cfg_wdata[BITPOS] : en_q[i];
        assign sts_wr[i] = cfg_be[LANE] ? cfg_wdata[BITPOS] : sts_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            en_q   <= '0;
            sts_q  <= '0;
        end else begin
            if (hit_ctrl) begin
                if (cfg_be[0]) begin
                    gate_q <= cfg_wdata[0];
                end
                en_q <= en_wr;
            end
            // set events take precedence over a software write
            sts_q <= (hit_sts ? sts_wr : sts_q) | set_vec;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == CTRL_OFF) begin
            cfg_rdata[0]                   = gate_q;
            cfg_rdata[FIELD_MSB:FIELD_LSB] = en_q;
        end else if (cfg_addr == STS_OFF) begin
            cfg_rdata[FIELD_MSB:FIELD_LSB] = sts_q;
        end
    end

    assign gate_o = gate_q;
    assign en_o   = en_q;
    assign sts_o  = sts_q;

endmodule

// File: rtl/smi_req_edge.sv
module smi_req_edge #(
    parameter int NUM_SRC = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_in,
    output logic [NUM_SRC-1:0] rise_o
);

    logic [NUM_SRC-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= req_in;
        end
    end

    assign rise_o = req_in & ~prev_q;

endmodule

// File: rtl/smi_apm_ports.sv
module smi_apm_ports #(
    parameter int               IO_AW    = 16,
    parameter logic [IO_AW-1:0] CMD_PORT = 'hB2,
    parameter logic [IO_AW-1:0] DAT_PORT = 'hB3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IO_AW-1:0] io_addr,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    output logic             cmd_stb
);

    logic [7:0] cmd_q;
    logic [7:0] dat_q;
    logic       hit_cmd;
    logic       hit_dat;

    assign hit_cmd = (io_addr == CMD_PORT);
    assign hit_dat = (io_addr == DAT_PORT);
    assign cmd_stb = io_wr && hit_cmd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            dat_q <= '0;
        end else begin
            if (cmd_stb) begin
                cmd_q <= io_wdata;
            end
            if (io_wr && hit_dat) begin
                dat_q <= io_wdata;
            end
        end
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (hit_cmd) begin
                io_rdata = cmd_q;
            end else if (hit_dat) begin
                io_rdata = dat_q;
            end
        end
    end

endmodule

// File: rtl/smi_out_fsm.sv
module smi_out_fsm
    import smi_swreq_pkg::*;
#(
    parameter int NUM_SRC = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gate,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] sts,
    output logic               smi_o
);

    smi_state_e state_q;
    smi_state_e state_d;
    logic       pending;

    assign pending = gate && (|(en & sts));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SMI_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SMI_IDLE:   if (pending)  state_d = SMI_ASSERT;
            SMI_ASSERT: if (!pending) state_d = SMI_IDLE;
        endcase
    end

    always_comb begin
        smi_o = 1'b0;
        unique case (state_q)
            SMI_IDLE:   smi_o = 1'b0;
            SMI_ASSERT: smi_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/smi_swreq_gen.sv
module smi_swreq_gen
    import smi_swreq_pkg::*;
#(
    parameter int               NUM_SRC   = 9,
    parameter int               APM_BIT   = 7,
    parameter int               FIELD_LSB = 16,
    parameter int               CFG_AW    = 8,
    parameter int               IO_AW     = 16,
    parameter logic [CFG_AW-1:0] CTRL_OFF = 'hA0,
    parameter logic [CFG_AW-1:0] STS_OFF  = 'hA8,
    parameter logic [IO_AW-1:0]  CMD_PORT = 'hB2,
    parameter logic [IO_AW-1:0]  DAT_PORT = 'hB3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [CFG_DW-1:0]   cfg_wdata,
    input  logic [CFG_BE_W-1:0] cfg_be,
    output logic [CFG_DW-1:0]   cfg_rdata,
    input  logic [IO_AW-1:0]    io_addr,
    input  logic                io_wr,
    input  logic                io_rd,
    input  logic [7:0]          io_wdata,
    output logic [7:0]          io_rdata,
    input  logic [NUM_SRC-1:0]  req_in,
    output logic                smi_req
);

    logic               gate_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] sts_q;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] apm_set;
    logic [NUM_SRC-1:0] set_vec;
    logic               apm_cmd_stb;

    smi_req_edge #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (req_in),
        .rise_o (rise)
    );

    smi_apm_ports #(
        .IO_AW    (IO_AW),
        .CMD_PORT (CMD_PORT),
        .DAT_PORT (DAT_PORT)
    ) u_apm (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .cmd_stb  (apm_cmd_stb)
    );

    // command-port write raises its own source when enabled
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_apm
        if (i == APM_BIT) begin : g_hit
            assign apm_set[i] = apm_cmd_stb && en_q[i];
        end else begin : g_miss
            assign apm_set[i] = 1'b0;
        end
    end

    assign set_vec = rise | apm_set;

    smi_cfg_regs #(
        .NUM_SRC   (NUM_SRC),
        .FIELD_LSB (FIELD_LSB),
        .CFG_AW    (CFG_AW),
        .CTRL_OFF  (CTRL_OFF),
        .STS_OFF   (STS_OFF)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_be    (cfg_be),
        .set_vec   (set_vec),
        .gate_o    (gate_q),
        .en_o      (en_q),
        .sts_o     (sts_q),
        .cfg_rdata (cfg_rdata)
    );

    smi_out_fsm #(.NUM_SRC(NUM_SRC)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .gate  (gate_q),
        .en    (en_q),
        .sts   (sts_q),
        .smi_o (smi_req)
    );

endmodule

// File: rtl/smi_swreq_chk.sv
module smi_swreq_chk #(
    parameter int               NUM_SRC  = 9,
    parameter int               APM_BIT  = 7,
    parameter int               IO_AW    = 16,
    parameter logic [IO_AW-1:0] DAT_PORT = 'hB3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] req_in,
    input logic [IO_AW-1:0]   io_addr,
    input logic               io_wr,
    input logic               io_rd,
    input logic [7:0]         io_rdata,
    input logic               gate,
    input logic [NUM_SRC-1:0] en,
    input logic [NUM_SRC-1:0] sts,
    input logic               cmd_stb,
    input logic               smi_req
);

    logic [NUM_SRC-1:0] seen_q;
    logic [NUM_SRC-1:0] ups;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= req_in;
    end
    assign ups = req_in & ~seen_q;

    // R3: a closed gate keeps the request low on the next cycle
    p_gate_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> !smi_req);

    // R3: no flags pending means no request next cycle
    p_no_flags_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sts == '0) |=> !smi_req);

    // R3: a rising request needs the gate open one cycle before
    p_rise_needs_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smi_req) |-> $past(gate));

    // R5: an enabled command write raises the command source flag
    p_cmd_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && en[APM_BIT]) |=> sts[APM_BIT]);

    // R6: a data-port write never acts as a command write
    p_dat_no_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == DAT_PORT) |-> !cmd_stb);

    // R7: every rising request line leaves its flag set
    p_edge_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ups != '0) |=> ((sts & $past(ups)) == $past(ups)));

    // R10: no read strobe, no read data
    p_idle_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> (io_rdata == 8'h00));

endmodule

bind smi_swreq_gen smi_swreq_chk #(
    .NUM_SRC  (NUM_SRC),
    .APM_BIT  (APM_BIT),
    .IO_AW    (IO_AW),
    .DAT_PORT (DAT_PORT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_in   (req_in),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_rdata (io_rdata),
    .gate     (gate_q),
    .en       (en_q),
    .sts      (sts_q),
    .cmd_stb  (apm_cmd_stb),
    .smi_req  (smi_req)
);

// File: tb/smi_swreq_gen_bench.sv
module smi_swreq_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_rdata;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [8:0]  req_in = '0;
    logic        smi_req;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [7:0]  A_CTRL = 8'hA0;
    localparam logic [7:0]  A_STS  = 8'hA8;
    localparam logic [15:0] P_CMD  = 16'h00B2;
    localparam logic [15:0] P_DAT  = 16'h00B3;

    always #4 clk = ~clk;

    smi_swreq_gen u_smi_swreq_gen (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .req_in(req_in), .smi_req(smi_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic cfg_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic io_check(input string req, input logic [15:0] a, input logic [7:0] exp);
        io_addr = a; io_rd = 1'b1;
        #1;
        check(req, {24'h0, io_rdata}, {24'h0, exp});
        io_rd = 1'b0;
    endtask

    // one more edge for the output stage, then sample the request level
    task automatic smi_check(input string req, input logic exp);
        @(negedge clk);
        check(req, {31'h0, smi_req}, {31'h0, exp});
    endtask

    task automatic t_reset_state;
        check("R9 smi after reset", {31'h0, smi_req}, 32'h0);
        cfg_check("R9 ctrl after reset", A_CTRL, 32'h0);
        cfg_check("R9 sts after reset", A_STS, 32'h0);
        io_check("R9 cmd byte after reset", P_CMD, 8'h00);
        io_check("R9 data byte after reset", P_DAT, 8'h00);
    endtask

    task automatic t_ctrl_fields;
        cfg_write(A_CTRL, 32'hFFFF_FFFF, 4'hF);
        cfg_check("R1 ctrl field layout", A_CTRL, 32'h01FF_0001);
        cfg_write(A_CTRL, 32'h0000_0000, 4'b1000);
        cfg_check("R1 lane 3 only", A_CTRL, 32'h00FF_0001);
        cfg_write(8'hA4, 32'hFFFF_FFFF, 4'hF);
        cfg_check("R2 other offset ignored ctrl", A_CTRL, 32'h00FF_0001);
        cfg_check("R2 other offset ignored sts", A_STS, 32'h0);
        cfg_check("R2 other offset reads zero", 8'hA4, 32'h0);
        cfg_write(A_CTRL, 32'h0, 4'hF);
    endtask

    task automatic t_gating;
        cfg_write(A_CTRL, 32'h01FF_0001, 4'hF);
        cfg_write(A_STS, 32'hFFFF_FFFF, 4'b0100);
        cfg_check("R2 sts lane 2 write", A_STS, 32'h00FF_0000);
        check("R3 not yet raised", {31'h0, smi_req}, 32'h0);
        smi_check("R3 raised after one edge", 1'b1);
        cfg_write(A_CTRL, 32'h01FF_0000, 4'hF);
        smi_check("R3 gate closed", 1'b0);
        cfg_write(A_CTRL, 32'h0100_0001, 4'hF);
        smi_check("R3 enable mismatch", 1'b0);
        cfg_write(A_STS, 32'h0100_0000, 4'b1000);
        cfg_check("R2 sts lane 3 write", A_STS, 32'h01FF_0000);
        smi_check("R3 bit 8 pair", 1'b1);
        cfg_write(A_STS, 32'h0, 4'hF);
        cfg_check("R2 sts cleared by write", A_STS, 32'h0);
        smi_check("R3 cleared flags drop request", 1'b0);
    endtask

    task automatic t_apm_cmd;
        cfg_write(A_CTRL, 32'h0080_0001, 4'hF);
        io_write(P_CMD, 8'h5A);
        cfg_check("R5 command sets flag 7", A_STS, 32'h0080_0000);
        smi_check("R5 command raises request", 1'b1);
        io_check("R4 command byte stored", P_CMD, 8'h5A);
        cfg_write(A_STS, 32'h0, 4'hF);
        smi_check("R5 request drops after clear", 1'b0);
        cfg_write(A_CTRL, 32'h0100_0001, 4'hF);
        io_write(P_CMD, 8'hC3);
        cfg_check("R5 disabled source no flag", A_STS, 32'h0);
        smi_check("R5 disabled source no request", 1'b0);
        io_check("R4 command byte updated", P_CMD, 8'hC3);
    endtask

    task automatic t_apm_data;
        cfg_write(A_CTRL, 32'h01FF_0001, 4'hF);
        io_write(P_DAT, 8'h77);
        cfg_check("R6 data write leaves flags", A_STS, 32'h0);
        smi_check("R6 data write no request", 1'b0);
        io_check("R6 data byte stored", P_DAT, 8'h77);
        io_check("R6 command byte untouched", P_CMD, 8'hC3);
    endtask

    task automatic t_req_edge;
        cfg_write(A_CTRL, 32'h0008_0001, 4'hF);
        @(negedge clk);
        req_in[3] = 1'b1;
        @(negedge clk);
        cfg_check("R7 edge sets flag 3", A_STS, 32'h0008_0000);
        smi_check("R7 edge raises request", 1'b1);
        cfg_write(A_STS, 32'h0, 4'hF);
        cfg_check("R7 held line does not reset flag", A_STS, 32'h0);
        smi_check("R7 request drops with held line", 1'b0);
        req_in[3] = 1'b0;
        req_in[8] = 1'b1;
        @(negedge clk);
        req_in[8] = 1'b0;
        cfg_check("R7 pulse sets flag 8", A_STS, 32'h0100_0000);
        smi_check("R3 disabled source stays quiet", 1'b0);
    endtask

    task automatic t_priority;
        cfg_write(A_CTRL, 32'h0080_0001, 4'hF);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = A_STS; cfg_wdata = 32'h0; cfg_be = 4'hF;
        io_wr = 1'b1; io_addr = P_CMD; io_wdata = 8'h11;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0; io_wr = 1'b0;
        cfg_check("R8 set beats clear", A_STS, 32'h0080_0000);
        smi_check("R8 request after collision", 1'b1);
    endtask

    task automatic t_io_idle;
        io_addr = P_CMD; io_rd = 1'b0;
        #1;
        check("R10 no strobe reads zero", {24'h0, io_rdata}, 32'h0);
        io_check("R10 unmapped port reads zero", 16'h0080, 8'h00);
    endtask

    task automatic t_mid_reset;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9 smi cleared by reset", {31'h0, smi_req}, 32'h0);
        cfg_check("R9 ctrl cleared by reset", A_CTRL, 32'h0);
        cfg_check("R9 sts cleared by reset", A_STS, 32'h0);
        io_check("R9 cmd cleared by reset", P_CMD, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_ctrl_fields();
        t_gating();
        t_apm_cmd();
        t_apm_data();
        t_req_edge();
        t_priority();
        t_io_idle();
        t_mid_reset();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule